// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Transceiver

This block sends and receives asynchronous serial characters whose layout is set by software. A character holds 5 to 9 data bits. An even or odd parity bit may follow the data, and the frame ends with one or two stop bits. Software sets the layout and the two enables through a four-entry register bus. It hands characters to the transmitter and takes them from the receiver through a shared data address. A free-running tick at sixteen times the bit rate times both directions.

For 9-bit characters, the top data bit does not fit in the 8-bit data register, so it travels in a control bit. When sending, software sets that bit first and then writes the data register, which takes both parts at once. When receiving, software reads the top bit from the control register first and then reads the data register, because reading the data register removes the character. Clearing the transmit enable does not cut off traffic. The transmitter keeps running until the character being shifted and the one waiting in the holding buffer have both gone out, and only then releases the output pin.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset, the format register (address 2) reads 0x03, which selects 8 data bits, no parity and one stop bit. The control register (address 1) reads 0x00. The status register (address 3) reads 0x01. `txd` is 1 and `txd_oe` is 0.
- R2: A transmitted frame has the following fields, in order:
  - one low start bit;
  - the data bits, least significant first;
  - the parity bit, when parity is enabled;
  - the stop bits, driven high.

  Every bit lasts exactly 16 `baud_tick` pulses, `txd` changes only in the cycle after a tick, and the idle line is high.
- R3: The character size code is {control bit 2, format bits 1:0}. Codes 000, 001, 010 and 011 give 5, 6, 7 and 8 data bits. Code 111 gives 9 data bits. Codes 100, 101 and 110 give 8 data bits.
- R4: Format bits 3:2 set the parity mode: 00 gives no parity, 01 is reserved and also gives no parity, 10 gives even parity and 11 gives odd parity. The parity bit is the XOR of the data bits, inverted when the mode is odd.
- R5: Format bit 4 selects two stop bits when set and one stop bit when clear.
- R6: A write to the data register (address 0) loads the transmit buffer with {control bit 3, written byte}. In 9-bit mode, control bit 3 is sent as data bit 8.
- R7: The receive registers behave as follows:
  - Control bit 4 holds bit 8 of the stored received character, and it is 0 for characters shorter than 9 bits.
  - Reading control bit 4 leaves the character in place.
  - A read of address 0 returns the low 8 bits and clears receive-complete. A character stored in the same cycle takes priority over the clear.
- R8: When control bit 0 (transmit enable) is cleared, the character being shifted and the buffered character are both still sent in full. `txd_oe` falls only after both have gone out.
- R9: While the transmitter is released, `txd_oe` is 0 and `txd` is 1. A data write while control bit 0 is clear is ignored, and so is a data write while the buffer is full.
- R10: Status bit 0 (transmit buffer empty) clears on an accepted data write. It sets again when the buffer contents move into the shift register.
- R11: The receiver samples each bit at mid-bit, counted in ticks. A start bit that is no longer low 8 ticks after detection is discarded, and no character is stored.
- R12: Status bit 2 is set when the received parity bit does not match the computed parity. Status bit 3 is set when the first stop bit is sampled low. Both flags are updated each time a character is stored.
- R13: Status bit 1 (receive complete) is set when a character is stored. While control bit 1 (receive enable) is clear, the receiver ignores `rxd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 pops the received character |
| reg_addr | input | 2 | Register address: 0 data, 1 control, 2 format, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Output enable for `txd`; low while the transmitter is released |

## Verification
A transmit state machine that advances one step too few or too many shows at `txd` within one frame. The bench sees a data bit, the parity bit or a stop bit at the wrong mid-bit sample, or no stop level at all.

A wrong latch of the character size or the parity mode affects the next character sent. It appears as wrong data bits or a wrong parity level.

The receive path is judged from the status and data registers read right after each frame. A missed sample point, a wrong alignment of short characters, or a stale error flag is visible in the first read after that frame.

Faults in the enable hand-off have two possible symptoms. If the release comes too early, the buffered character is cut short. If the release never comes, `txd_oe` stays high in the cycles after the buffer drains.

// File: rtl/uart_fmt_pkg.sv
`timescale 1ns/1ps
package uart_fmt_pkg;

    localparam int MAXW = 9;

    typedef struct packed {
        logic [2:0] size;
        logic [1:0] pmode;
        logic       two_stop;
    } frame_cfg_t;

    // size code -> number of data bits; unlisted codes fall back to 8
    function automatic logic [3:0] char_bits(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'b000:  n = 4'd5;
            3'b001:  n = 4'd6;
            3'b010:  n = 4'd7;
            3'b111:  n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

    function automatic logic [MAXW-1:0] low_mask(input logic [3:0] n);
        return 9'h1FF >> (4'd9 - n);
    endfunction

    function automatic logic parity_of(input logic [MAXW-1:0] d, input logic [3:0] n,
                                       input logic odd);
        return (^(d & low_mask(n))) ^ odd;
    endfunction

endpackage

// File: rtl/uart_regs.sv
`timescale 1ns/1ps
module uart_regs
    import uart_fmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_addr,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    output frame_cfg_t      cfg,
    output logic            tx_en_sw,
    output logic            rx_en,
    output logic            buf_valid,
    output logic [MAXW-1:0] buf_data,
    input  logic            tx_take,
    input  logic            rx_store,
    input  logic [MAXW-1:0] rx_word,
    input  logic            rx_perr,
    input  logic            rx_ferr,
    output logic            rx_done
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_FMT  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    logic            size_hi_q, tx_b8_q, two_q, perr_q, ferr_q;
    logic [1:0]      size_lo_q, pmode_q;
    logic [MAXW-1:0] held_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_sw  <= 1'b0;
            rx_en     <= 1'b0;
            size_hi_q <= 1'b0;
            tx_b8_q   <= 1'b0;
            size_lo_q <= 2'b11;
            pmode_q   <= 2'b00;
            two_q     <= 1'b0;
            buf_valid <= 1'b0;
            buf_data  <= '0;
            held_q    <= '0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            rx_done   <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    A_CTRL: begin
                        tx_en_sw  <= reg_wdata[0];
                        rx_en     <= reg_wdata[1];
                        size_hi_q <= reg_wdata[2];
                        tx_b8_q   <= reg_wdata[3];
                    end
                    A_FMT: begin
                        size_lo_q <= reg_wdata[1:0];
                        pmode_q   <= reg_wdata[3:2];
                        two_q     <= reg_wdata[4];
                    end
                    A_DATA: begin
                        if (tx_en_sw && !buf_valid) begin
                            buf_data  <= {tx_b8_q, reg_wdata};
                            buf_valid <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (tx_take) buf_valid <= 1'b0;
            if (rx_store) begin
                held_q  <= rx_word;
                perr_q  <= rx_perr;
                ferr_q  <= rx_ferr;
                rx_done <= 1'b1;
            end else if (reg_rd && reg_addr == A_DATA) begin
                rx_done <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg.size     = {size_hi_q, size_lo_q};
        cfg.pmode    = pmode_q;
        cfg.two_stop = two_q;
        unique case (reg_addr)
            A_DATA:  reg_rdata = held_q[7:0];
            A_CTRL:  reg_rdata = {3'b000, held_q[8], tx_b8_q, size_hi_q, rx_en, tx_en_sw};
            A_FMT:   reg_rdata = {3'b000, two_q, pmode_q, size_lo_q};
            default: reg_rdata = {4'b0000, ferr_q, perr_q, rx_done, !buf_valid};
        endcase
    end
endmodule

// File: rtl/uart_tx_fsm.sv
`timescale 1ns/1ps
module uart_tx_fsm
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  frame_cfg_t      cfg,
    input  logic            tx_en_sw,
    input  logic            buf_valid,
    input  logic [MAXW-1:0] buf_data,
    output logic            tx_take,
    output logic            tx_busy,
    output logic            txd,
    output logic            txd_oe
);
    localparam int            CW   = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP1, T_STOP2} tx_state_e;

    tx_state_e       state_q;
    logic [CW-1:0]   tick_q;
    logic [3:0]      idx_q, nbits_q;
    logic [MAXW-1:0] sh_q;
    logic            par_en_q, par_q, two_q, on_q;
    logic            bit_end, frame_end, start_ok;
    logic [3:0]      new_bits;

    always_comb begin
        new_bits  = char_bits(cfg.size);
        bit_end   = baud_tick && (state_q != T_IDLE) && (tick_q == LAST);
        frame_end = bit_end && ((state_q == T_STOP1 && !two_q) || state_q == T_STOP2);
        start_ok  = baud_tick && buf_valid && on_q && (state_q == T_IDLE || frame_end);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= T_IDLE;
            tick_q   <= '0;
            idx_q    <= '0;
            nbits_q  <= 4'd8;
            sh_q     <= '0;
            par_en_q <= 1'b0;
            par_q    <= 1'b0;
            two_q    <= 1'b0;
            on_q     <= 1'b0;
        end else begin
            if (tx_en_sw)                            on_q <= 1'b1;
            else if (state_q == T_IDLE && !buf_valid) on_q <= 1'b0;
            if (baud_tick && state_q != T_IDLE)
                tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
            if (start_ok) begin
                state_q  <= T_START;
                tick_q   <= '0;
                sh_q     <= buf_data;
                nbits_q  <= new_bits;
                par_en_q <= cfg.pmode[1];
                par_q    <= parity_of(buf_data, new_bits, cfg.pmode[0]);
                two_q    <= cfg.two_stop;
            end else if (bit_end) begin
                unique case (state_q)
                    T_START: begin
                        state_q <= T_DATA;
                        idx_q   <= '0;
                    end
                    T_DATA: begin
                        sh_q <= sh_q >> 1;
                        if (idx_q == nbits_q - 4'd1) state_q <= par_en_q ? T_PAR : T_STOP1;
                        else                         idx_q   <= idx_q + 4'd1;
                    end
                    T_PAR:   state_q <= T_STOP1;
                    T_STOP1: state_q <= two_q ? T_STOP2 : T_IDLE;
                    T_STOP2: state_q <= T_IDLE;
                    default: state_q <= T_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        tx_take = start_ok;
        tx_busy = (state_q != T_IDLE);
        txd_oe  = on_q;
        unique case (state_q)
            T_START: txd = 1'b0;
            T_DATA:  txd = sh_q[0];
            T_PAR:   txd = par_q;
            default: txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx_fsm.sv
`timescale 1ns/1ps
module uart_rx_fsm
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            baud_tick,
    input  frame_cfg_t      cfg,
    input  logic            rx_en,
    input  logic            rxd,
    output logic            rx_store,
    output logic [MAXW-1:0] rx_word,
    output logic            rx_perr,
    output logic            rx_ferr
);
    localparam int            CW   = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_state_e;

    rx_state_e       state_q;
    logic            s1_q, s2_q;
    logic [CW-1:0]   tick_q;
    logic [3:0]      idx_q, nbits_q;
    logic [MAXW-1:0] sh_q, word_q, aligned;
    logic            par_en_q, odd_q, par_rx_q;
    logic            store_q, perr_q, ferr_q;
    logic            at_end;

    always_comb begin
        at_end  = baud_tick && (tick_q == LAST);
        aligned = sh_q >> (4'd9 - nbits_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= R_IDLE;
            s1_q     <= 1'b1;
            s2_q     <= 1'b1;
            tick_q   <= '0;
            idx_q    <= '0;
            nbits_q  <= 4'd8;
            sh_q     <= '0;
            par_en_q <= 1'b0;
            odd_q    <= 1'b0;
            par_rx_q <= 1'b0;
            store_q  <= 1'b0;
            word_q   <= '0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
        end else begin
            s1_q    <= rxd;
            s2_q    <= s1_q;
            store_q <= 1'b0;
            if (baud_tick && state_q != R_IDLE)
                tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
            if (!rx_en) begin
                state_q <= R_IDLE;
            end else begin
                unique case (state_q)
                    R_IDLE: if (baud_tick && !s2_q) begin
                        state_q  <= R_START;
                        tick_q   <= '0;
                        nbits_q  <= char_bits(cfg.size);
                        par_en_q <= cfg.pmode[1];
                        odd_q    <= cfg.pmode[0];
                    end
                    R_START: if (baud_tick && tick_q == MID) begin
                        tick_q  <= '0;
                        idx_q   <= '0;
                        state_q <= s2_q ? R_IDLE : R_DATA;
                    end
                    R_DATA: if (at_end) begin
                        sh_q <= {s2_q, sh_q[MAXW-1:1]};
                        if (idx_q == nbits_q - 4'd1) state_q <= par_en_q ? R_PAR : R_STOP;
                        else                         idx_q   <= idx_q + 4'd1;
                    end
                    R_PAR: if (at_end) begin
                        par_rx_q <= s2_q;
                        state_q  <= R_STOP;
                    end
                    R_STOP: if (at_end) begin
                        store_q <= 1'b1;
                        word_q  <= aligned;
                        perr_q  <= par_en_q && (parity_of(aligned, nbits_q, odd_q) != par_rx_q);
                        ferr_q  <= !s2_q;
                        state_q <= R_IDLE;
                    end
                    default: state_q <= R_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        rx_store = store_q;
        rx_word  = word_q;
        rx_perr  = perr_q;
        rx_ferr  = ferr_q;
    end
endmodule

// File: rtl/uart_frame_xcvr.sv
`timescale 1ns/1ps
module uart_frame_xcvr
    import uart_fmt_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       baud_tick,
    input  logic       rxd,
    output logic       txd,
    output logic       txd_oe
);
    frame_cfg_t      cfg;
    logic            tx_en_sw, rx_en, buf_valid, tx_take, tx_busy;
    logic            rx_store, rx_perr, rx_ferr, rx_done;
    logic [MAXW-1:0] buf_data, rx_word;

    uart_regs regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg(cfg), .tx_en_sw(tx_en_sw),
        .rx_en(rx_en), .buf_valid(buf_valid), .buf_data(buf_data), .tx_take(tx_take),
        .rx_store(rx_store), .rx_word(rx_word), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
        .rx_done(rx_done)
    );

    uart_tx_fsm #(.OVS(OVS)) tx_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg(cfg), .tx_en_sw(tx_en_sw),
        .buf_valid(buf_valid), .buf_data(buf_data), .tx_take(tx_take), .tx_busy(tx_busy),
        .txd(txd), .txd_oe(txd_oe)
    );

    uart_rx_fsm #(.OVS(OVS)) rx_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .cfg(cfg), .rx_en(rx_en),
        .rxd(rxd), .rx_store(rx_store), .rx_word(rx_word), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr)
    );
endmodule

// File: rtl/uart_frame_xcvr_chk.sv
`timescale 1ns/1ps
module uart_frame_xcvr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       baud_tick,
    input logic       txd,
    input logic       txd_oe,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic       tx_busy,
    input logic       buf_valid,
    input logic       rx_store,
    input logic       rx_done
);
    AST_TXD_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd)); // R2

    AST_RELEASE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd_oe) |-> (!tx_busy && !buf_valid)); // R8

    AST_RELEASED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> (txd && !tx_busy)); // R9

    AST_LOAD_EMPTIES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !buf_valid); // R10

    AST_POP_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && !rx_store) |=> !rx_done); // R7
endmodule

bind uart_frame_xcvr uart_frame_xcvr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .txd(txd), .txd_oe(txd_oe),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .tx_busy(tx_busy), .buf_valid(buf_valid),
    .rx_store(rx_store), .rx_done(rx_done)
);

// File: tb/uart_frame_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_frame_xcvr_tb_top;
    localparam int P = 32; // clocks per bit: 16 ticks, one tick every 2 clocks

    logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       baud_tick = 1'b0, rxd = 1'b1;
    logic       txd, txd_oe;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    uart_frame_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_tick(baud_tick), .rxd(rxd),
        .txd(txd), .txd_oe(txd_oe)
    );

    always #2 clk = ~clk;
    always @(posedge clk) baud_tick <= ~baud_tick;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] c);
        case (c)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

    function automatic bit par_of(input logic [8:0] d, input int n, input bit odd);
        bit p = odd;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a;
        @(negedge clk); d = reg_rdata; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic capture_tx(input int n, input bit pen, input bit two, output logic [8:0] d,
                              output bit p, output bit st, output bit s1, output bit s2,
                              output bit found);
        int t = 0;
        d = '0; p = 0; s2 = 1;
        while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
        found = (t < 3000);
        repeat (P/2) @(negedge clk); st = txd;
        for (int i = 0; i < n; i++) begin repeat (P) @(negedge clk); d[i] = txd; end
        if (pen) begin repeat (P) @(negedge clk); p = txd; end
        repeat (P) @(negedge clk); s1 = txd;
        if (two) begin repeat (P) @(negedge clk); s2 = txd; end
    endtask

    task automatic send_rx(input logic [8:0] d, input int n, input bit pen, input bit odd,
                           input bit flip, input bit badstop, input bit two);
        @(negedge clk); rxd = 1'b0; repeat (P) @(negedge clk);
        for (int i = 0; i < n; i++) begin rxd = d[i]; repeat (P) @(negedge clk); end
        if (pen) begin rxd = par_of(d, n, odd) ^ flip; repeat (P) @(negedge clk); end
        if (badstop) begin rxd = 1'b0; repeat (24) @(negedge clk); rxd = 1'b1; repeat (P-24) @(negedge clk); end
        else begin rxd = 1'b1; repeat (P) @(negedge clk); end
        if (two) repeat (P) @(negedge clk);
        rxd = 1'b1; repeat (P) @(negedge clk);
    endtask

    task automatic tx_frame(input logic [2:0] sz, input logic [1:0] pm, input bit two,
                            input logic [8:0] d, input string tag);
        logic [8:0] got; bit p, st, s1, s2, found;
        int n = nbits_of(sz);
        wr(2'd1, {4'b0000, d[8], sz[2], 2'b11});
        wr(2'd2, {3'b000, two, pm, sz[1:0]});
        fork
            capture_tx(n, pm[1], two, got, p, st, s1, s2, found);
            wr(2'd0, d[7:0]);
        join
        chk({tag, " R2 frame seen"}, found, 1);
        chk({tag, " R2 start low"}, st, 0);
        chk({tag, " R3 R6 data"}, got, d & (9'h1FF >> (9 - n)));
        if (pm[1]) chk({tag, " R4 parity"}, p, par_of(d, n, pm[0]));
        chk({tag, " R2 stop1 high"}, s1, 1);
        if (two) chk({tag, " R5 stop2 high"}, s2, 1);
    endtask

    task automatic rx_frame(input logic [2:0] sz, input logic [1:0] pm, input bit two,
                            input logic [8:0] d, input bit flip, input bit badstop,
                            input string tag);
        logic [7:0] v; int n = nbits_of(sz);
        logic [8:0] m = d & (9'h1FF >> (9 - n));
        wr(2'd1, {4'b0000, 1'b0, sz[2], 2'b11});
        wr(2'd2, {3'b000, two, pm, sz[1:0]});
        send_rx(m, n, pm[1], pm[0], flip, badstop, two);
        rd(2'd3, v);
        chk({tag, " R13 rx done"}, v[1], 1);
        chk({tag, " R12 parity err"}, v[2], pm[1] & flip);
        chk({tag, " R12 frame err"}, v[3], badstop);
        rd(2'd1, v);
        chk({tag, " R7 bit8"}, v[4], m[8]);
        rd(2'd0, v);
        chk({tag, " R11 low data"}, v, m[7:0]);
        rd(2'd3, v);
        chk({tag, " R7 pop clears done"}, v[1], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [8:0] ga, gb; bit p, st, s1, s2, fa, fb;
        int lows;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 txd_oe", txd_oe, 0);
        rd(2'd2, v); chk("R1 format", v, 8'h03);
        rd(2'd1, v); chk("R1 control", v, 8'h00);
        rd(2'd3, v); chk("R1 status", v, 8'h01);

        // R9 write while transmitter disabled is ignored
        wr(2'd0, 8'h5A);
        rd(2'd3, v); chk("R9 write ignored when disabled", v[0], 1);
        lows = 0;
        repeat (200) begin @(negedge clk); if (txd !== 1'b1 || txd_oe !== 1'b0) lows++; end
        chk("R9 line released", lows, 0);

        // directed transmit corners
        tx_frame(3'b011, 2'b00, 1'b0, 9'h0A5, "tx 8N1");
        tx_frame(3'b000, 2'b10, 1'b1, 9'h013, "tx 5E2");
        tx_frame(3'b111, 2'b11, 1'b0, 9'h1C3, "tx 9O1");
        tx_frame(3'b111, 2'b10, 1'b1, 9'h0FF, "tx 9E2 b8 low");
        tx_frame(3'b101, 2'b01, 1'b0, 9'h0F0, "tx reserved size R3 and parity R4");

        // random transmit frames
        for (int k = 0; k < 20; k++) begin
            tx_frame(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                     9'($urandom), "tx random");
        end

        // directed receive corners
        rx_frame(3'b011, 2'b00, 1'b0, 9'h03C, 1'b0, 1'b0, "rx 8N1");
        rx_frame(3'b111, 2'b10, 1'b0, 9'h155, 1'b0, 1'b0, "rx 9E1");
        rx_frame(3'b000, 2'b11, 1'b1, 9'h01B, 1'b1, 1'b0, "rx 5O2 bad parity");
        rx_frame(3'b010, 2'b00, 1'b0, 9'h07E, 1'b0, 1'b1, "rx 7N1 bad stop");
        rx_frame(3'b011, 2'b01, 1'b0, 9'h081, 1'b0, 1'b0, "rx reserved parity");

        // random receive frames
        for (int k = 0; k < 20; k++) begin
            logic [1:0] pm = 2'($urandom_range(0, 3));
            rx_frame(3'($urandom_range(0, 7)), pm, 1'($urandom_range(0, 1)), 9'($urandom),
                     1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 5) == 0), "rx random");
        end

        // R11 short start pulse is discarded
        @(negedge clk); rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (400) @(negedge clk);
        rd(2'd3, v); chk("R11 glitch rejected", v[1], 0);

        // R13 receiver disabled ignores line
        wr(2'd1, 8'h01);
        send_rx(9'h066, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        rd(2'd3, v); chk("R13 rx disabled ignores", v[1], 0);

        // R8 R10 R9: deferred release with buffered frame, full-buffer write dropped
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h03);
        fork
            begin
                capture_tx(8, 1'b0, 1'b0, ga, p, st, s1, s2, fa);
                capture_tx(8, 1'b0, 1'b0, gb, p, st, s1, s2, fb);
            end
            begin
                wr(2'd0, 8'h3C);
                v = 8'h00;
                for (int t = 0; t < 50 && v[0] == 1'b0; t++) rd(2'd3, v);
                wr(2'd0, 8'hC6);
                rd(2'd3, v); chk("R10 buffer full after write", v[0], 0);
                wr(2'd0, 8'h99);
                wr(2'd1, 8'h02);
            end
        join
        chk("R8 first frame", {fa, ga}, {1'b1, 9'h03C});
        chk("R8 buffered frame", {fb, gb}, {1'b1, 9'h0C6});
        chk("R8 still driven during stop", txd_oe, 1);
        repeat (40) @(negedge clk);
        chk("R8 released after drain", txd_oe, 0);
        rd(2'd3, v); chk("R10 buffer empty at end", v[0], 1);
        lows = 0;
        repeat (600) begin @(negedge clk); if (txd !== 1'b1) lows++; end
        chk("R9 dropped write never sent", lows, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule